// File: doc/BRIEF.md
# EEPROM Page-Write Buffer Controller

This block sits behind a two-wire serial slave engine and in front of a byte-wide storage array. The storage array is modelled here as registers: 256 locations in 16 pages of 16 bytes. The slave engine hands over a start byte address, then a stream of data bytes. It then signals the bus STOP that closes a write command. The block collects the bytes in a one-page staging buffer, and only the bytes that actually arrived are marked valid. On STOP it runs a fixed-length internal write cycle and holds a busy flag for the whole cycle. At the end of the cycle it moves the valid bytes into the array in one step.

The running byte pointer is made of a page part (upper address bits) and an offset part (lower address bits). The offset steps after every data byte and wraps inside the page. A long burst therefore overwrites its own earlier bytes and never reaches the next page. The pointer is reported back to the slave engine so that it can serve current-address reads.

A protect input locks the upper half of the array. The length of the write cycle is a parameter counted in clock cycles.

Top module: `eeprom_page_writer`

## Requirements
- R1: After reset, busy_o is 0, ptr_o is 0x00 and every array location reads 0x00.
- R2: An accepted address strobe loads ptr_o with addr_i on the next cycle. It also discards every byte already buffered but not yet written to the array.
- R3: Each accepted data byte is stored at the current pointer. ptr_o[3:0] then steps by one and wraps from 15 to 0, while ptr_o[7:4] stays unchanged.
- R4: When more than 16 bytes arrive in one command, each later byte replaces the earlier byte at the same offset. The array receives only the last value for each offset.
- R5: A STOP with at least one buffered byte, unless blocked by R8, drives busy_o high from the next cycle for exactly WR_CYCLES cycles.
- R6: The array changes only at the clock edge where busy_o falls. At that edge every buffered byte is written, and all other locations keep their contents.
- R7: A STOP with no buffered data byte starts no write cycle. busy_o stays 0 and the array is unchanged.
- R8: If wp_i is 1 when the STOP is accepted and ptr_o[7] is 1 (addresses 0x80 to 0xFF), no write cycle starts and the buffered bytes are dropped. When wp_i is 0, upper-half addresses are written normally.
- R9: wp_i has no effect on commands whose page lies in the lower half (addresses 0x00 to 0x7F).
- R10: While busy_o is 1, address strobes, data strobes and STOPs are ignored. ptr_o holds its value, and nothing is buffered for a later commit.
- R11: Strobe priority in one cycle is STOP, then address, then data. After a commit the buffer is empty, so a following STOP alone starts no cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| addr_valid_i | input | 1 | Start byte address strobe |
| addr_i | input | ADDR_W | Start byte address |
| data_valid_i | input | 1 | Data byte strobe |
| data_i | input | DATA_W | Data byte |
| stop_i | input | 1 | STOP closing a write command |
| wp_i | input | 1 | Upper-half write protect |
| rd_addr_i | input | ADDR_W | Array read address |
| rd_data_o | output | DATA_W | Array read data (combinational) |
| busy_o | output | 1 | Internal write cycle in progress |
| ptr_o | output | ADDR_W | Current byte pointer {page, offset} |

## Verification
A wrong offset or page register shows on ptr_o one cycle after the strobe that updated it. The valid mask cannot be seen directly, so an error there appears in two ways. If the mask is wrongly empty or full, busy_o is wrong on the cycle after STOP. If individual bits are wrong, the wrong locations differ on rd_data_o from the cycle after busy_o falls. A miscounted timer shows as busy_o falling on the wrong cycle, and the array update moves with it. The protect decision is visible both in busy_o and in the upper-half contents of the array.

// File: rtl/epw_pkg.sv
`timescale 1ns/1ps
package epw_pkg;
  typedef enum logic [1:0] {
    CMD_NONE = 2'd0,
    CMD_STOP = 2'd1,
    CMD_ADDR = 2'd2,
    CMD_DATA = 2'd3
  } epw_cmd_e;
endpackage

// File: rtl/epw_page_buf.sv
`timescale 1ns/1ps
module epw_page_buf
  import epw_pkg::*;
#(
  parameter int ADDR_W = 8,
  parameter int DATA_W = 8,
  parameter int OFF_W  = 4,
  localparam int PAGE_W = ADDR_W - OFF_W,
  localparam int SLOTS  = 1 << OFF_W
) (
  input  logic                    clk_i,
  input  logic                    rst_ni,
  input  epw_cmd_e                cmd_i,
  input  logic [ADDR_W-1:0]       addr_i,
  input  logic [DATA_W-1:0]       data_i,
  input  logic                    clear_i,
  output logic [PAGE_W-1:0]       page_o,
  output logic [OFF_W-1:0]        off_o,
  output logic [SLOTS-1:0]        mask_o,
  output logic [SLOTS*DATA_W-1:0] bytes_o
);
  logic [PAGE_W-1:0] page_q;
  logic [OFF_W-1:0]  off_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      page_q <= '0;
      off_q  <= '0;
    end else if (cmd_i == CMD_ADDR) begin
      page_q <= addr_i[ADDR_W-1:OFF_W];
      off_q  <= addr_i[OFF_W-1:0];
    end else if (cmd_i == CMD_DATA) begin
      off_q  <= off_q + OFF_W'(1);  // wraps inside the page
    end
  end

  for (genvar g = 0; g < SLOTS; g++) begin : g_slot
    logic [DATA_W-1:0] byte_q;
    logic              vld_q;
    logic              hit;
    assign hit = (cmd_i == CMD_DATA) && (off_q == OFF_W'(g));

    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        byte_q <= '0;
        vld_q  <= 1'b0;
      end else begin
        if (hit) byte_q <= data_i;
        if (clear_i || cmd_i == CMD_ADDR) vld_q <= 1'b0;
        else if (hit)                     vld_q <= 1'b1;
      end
    end

    assign mask_o[g]                   = vld_q;
    assign bytes_o[g*DATA_W +: DATA_W] = byte_q;
  end

  assign page_o = page_q;
  assign off_o  = off_q;
endmodule

// File: rtl/epw_cycle_timer.sv
`timescale 1ns/1ps
module epw_cycle_timer #(
  parameter int CYCLES = 1250000,
  localparam int CNT_W = (CYCLES > 1) ? $clog2(CYCLES) : 1
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic start_i,
  output logic busy_o,
  output logic done_o
);
  logic             busy_q;
  logic [CNT_W-1:0] cnt_q;

  assign done_o = busy_q && (cnt_q == '0);
  assign busy_o = busy_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      busy_q <= 1'b0;
      cnt_q  <= '0;
    end else if (!busy_q) begin
      if (start_i) begin
        busy_q <= 1'b1;
        cnt_q  <= CNT_W'(CYCLES - 1);
      end
    end else if (done_o) begin
      busy_q <= 1'b0;
    end else begin
      cnt_q <= cnt_q - CNT_W'(1);
    end
  end
endmodule

// File: rtl/epw_array.sv
`timescale 1ns/1ps
module epw_array #(
  parameter int ADDR_W = 8,
  parameter int DATA_W = 8,
  parameter int OFF_W  = 4,
  localparam int PAGE_W = ADDR_W - OFF_W,
  localparam int SLOTS  = 1 << OFF_W,
  localparam int DEPTH  = 1 << ADDR_W
) (
  input  logic                    clk_i,
  input  logic                    rst_ni,
  input  logic                    we_i,
  input  logic [PAGE_W-1:0]       page_i,
  input  logic [SLOTS-1:0]        mask_i,
  input  logic [SLOTS*DATA_W-1:0] bytes_i,
  input  logic [ADDR_W-1:0]       rd_addr_i,
  output logic [DATA_W-1:0]       rd_data_o
);
  logic [DATA_W-1:0] mem_q [DEPTH];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int i = 0; i < DEPTH; i++) mem_q[i] <= '0;
    end else if (we_i) begin
      for (int j = 0; j < SLOTS; j++) begin
        if (mask_i[j]) mem_q[{page_i, OFF_W'(j)}] <= bytes_i[j*DATA_W +: DATA_W];
      end
    end
  end

  assign rd_data_o = mem_q[rd_addr_i];
endmodule

// File: rtl/eeprom_page_writer.sv
`timescale 1ns/1ps
module eeprom_page_writer
  import epw_pkg::*;
#(
  parameter int ADDR_W    = 8,
  parameter int DATA_W    = 8,
  parameter int OFF_W     = 4,
  parameter int WR_CYCLES = 1250000,
  localparam int PAGE_W = ADDR_W - OFF_W,
  localparam int SLOTS  = 1 << OFF_W
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              addr_valid_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic              data_valid_i,
  input  logic [DATA_W-1:0] data_i,
  input  logic              stop_i,
  input  logic              wp_i,
  input  logic [ADDR_W-1:0] rd_addr_i,
  output logic [DATA_W-1:0] rd_data_o,
  output logic              busy_o,
  output logic [ADDR_W-1:0] ptr_o
);
  epw_cmd_e                cmd;
  logic [PAGE_W-1:0]       page;
  logic [OFF_W-1:0]        off;
  logic [SLOTS-1:0]        mask;
  logic [SLOTS*DATA_W-1:0] bytes;
  logic                    busy, done, start, protect, clear;

  // strobes are dropped while a cycle runs; STOP beats address beats data
  always_comb begin
    cmd = CMD_NONE;
    if (!busy) begin
      if (stop_i)            cmd = CMD_STOP;
      else if (addr_valid_i) cmd = CMD_ADDR;
      else if (data_valid_i) cmd = CMD_DATA;
    end
  end

  assign protect = wp_i && page[PAGE_W-1];
  assign start   = (cmd == CMD_STOP) && (|mask) && !protect;
  assign clear   = ((cmd == CMD_STOP) && !start) || done;

  epw_page_buf #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .OFF_W(OFF_W)) u_buf (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .cmd_i   (cmd),
    .addr_i  (addr_i),
    .data_i  (data_i),
    .clear_i (clear),
    .page_o  (page),
    .off_o   (off),
    .mask_o  (mask),
    .bytes_o (bytes)
  );

  epw_cycle_timer #(.CYCLES(WR_CYCLES)) u_tmr (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .start_i (start),
    .busy_o  (busy),
    .done_o  (done)
  );

  epw_array #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .OFF_W(OFF_W)) u_arr (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .we_i      (done),
    .page_i    (page),
    .mask_i    (mask),
    .bytes_i   (bytes),
    .rd_addr_i (rd_addr_i),
    .rd_data_o (rd_data_o)
  );

  assign busy_o = busy;
  assign ptr_o  = {page, off};
endmodule

// File: rtl/epw_checker.sv
`timescale 1ns/1ps
module epw_checker #(
  parameter int ADDR_W    = 8,
  parameter int DATA_W    = 8,
  parameter int OFF_W     = 4,
  parameter int WR_CYCLES = 16
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              addr_valid_i,
  input logic [ADDR_W-1:0] addr_i,
  input logic              data_valid_i,
  input logic [DATA_W-1:0] data_i,
  input logic              stop_i,
  input logic              wp_i,
  input logic [ADDR_W-1:0] rd_addr_i,
  input logic [DATA_W-1:0] rd_data_o,
  input logic              busy_o,
  input logic [ADDR_W-1:0] ptr_o
);
  logic seen_q;
  int   blen_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      seen_q <= 1'b0;
      blen_q <= 0;
    end else begin
      blen_q <= busy_o ? blen_q + 1 : 0;
      if (!busy_o) begin
        if (stop_i || addr_valid_i) seen_q <= 1'b0;
        else if (data_valid_i)      seen_q <= 1'b1;
      end
    end
  end

  a_r2_addr_load: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (addr_valid_i && !stop_i && !busy_o) |=> (ptr_o == $past(addr_i)));

  a_r3_offset_step: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (data_valid_i && !addr_valid_i && !stop_i && !busy_o) |=>
      (ptr_o[ADDR_W-1:OFF_W] == $past(ptr_o[ADDR_W-1:OFF_W]) &&
       ptr_o[OFF_W-1:0] == $past(ptr_o[OFF_W-1:0]) + OFF_W'(1)));

  a_r5_start: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (stop_i && !busy_o && seen_q && !(wp_i && ptr_o[ADDR_W-1])) |=> busy_o);

  a_r5_length: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(busy_o) |-> (blen_q == WR_CYCLES));

  a_r6_mem_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($stable(rd_addr_i) && !$fell(busy_o)) |-> $stable(rd_data_o));

  a_r7_empty_stop: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (stop_i && !busy_o && !seen_q) |=> !busy_o);

  a_r8_protected: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (stop_i && !busy_o && wp_i && ptr_o[ADDR_W-1]) |=> !busy_o);

  a_r10_ptr_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_o |=> $stable(ptr_o));
endmodule

bind eeprom_page_writer epw_checker #(
  .ADDR_W(ADDR_W), .DATA_W(DATA_W), .OFF_W(OFF_W), .WR_CYCLES(WR_CYCLES)
) u_chk (
  .clk_i        (clk_i),
  .rst_ni       (rst_ni),
  .addr_valid_i (addr_valid_i),
  .addr_i       (addr_i),
  .data_valid_i (data_valid_i),
  .data_i       (data_i),
  .stop_i       (stop_i),
  .wp_i         (wp_i),
  .rd_addr_i    (rd_addr_i),
  .rd_data_o    (rd_data_o),
  .busy_o       (busy_o),
  .ptr_o        (ptr_o)
);

// File: tb/sim_eeprom_page_writer.sv
`timescale 1ns/1ps
module sim_eeprom_page_writer;
  localparam int WR = 20;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       addr_valid = 1'b0, data_valid = 1'b0, stop = 1'b0, wp = 1'b0;
  logic [7:0] addr = '0, data = '0, rd_addr = '0;
  logic [7:0] rd_data, ptr;
  logic       busy;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  always #2 clk = ~clk;

  eeprom_page_writer #(.ADDR_W(8), .DATA_W(8), .OFF_W(4), .WR_CYCLES(WR)) u0 (
    .clk_i(clk), .rst_ni(rst_n),
    .addr_valid_i(addr_valid), .addr_i(addr),
    .data_valid_i(data_valid), .data_i(data),
    .stop_i(stop), .wp_i(wp),
    .rd_addr_i(rd_addr), .rd_data_o(rd_data),
    .busy_o(busy), .ptr_o(ptr)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s act=%0h exp=%0h t=%0t", tag, act, exp, $time);
    end
  endtask

  // behavioural reference model
  logic [7:0]  m_mem [256];
  logic [7:0]  m_ptr;
  bit          m_busy;
  int          m_cnt;
  logic [15:0] m_q[$];

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < 256; i++) m_mem[i] = 8'h00;
      m_ptr = 8'h00; m_busy = 1'b0; m_cnt = 0; m_q.delete();
    end else if (m_busy) begin
      m_cnt--;
      if (m_cnt == 0) begin
        foreach (m_q[k]) m_mem[m_q[k][15:8]] = m_q[k][7:0];
        m_q.delete();
        m_busy = 1'b0;
      end
    end else if (stop) begin
      if (m_q.size() > 0 && !(wp && m_ptr[7])) begin
        m_busy = 1'b1; m_cnt = WR;
      end else m_q.delete();
    end else if (addr_valid) begin
      m_ptr = addr; m_q.delete();
    end else if (data_valid) begin
      m_q.push_back({m_ptr, data});
      m_ptr = {m_ptr[7:4], 4'(m_ptr[3:0] + 4'd1)};
    end
  end

  always @(negedge clk) begin
    if (rst_n && !done) begin
      chk("R5 busy", busy, m_busy);
      chk("R3 ptr", ptr, m_ptr);
    end
  end

  task automatic t_addr(input logic [7:0] a);
    @(negedge clk); addr_valid = 1'b1; addr = a;
    @(negedge clk); addr_valid = 1'b0;
  endtask
  task automatic t_data(input logic [7:0] d);
    @(negedge clk); data_valid = 1'b1; data = d;
    @(negedge clk); data_valid = 1'b0;
  endtask
  task automatic t_stop();
    @(negedge clk); stop = 1'b1;
    @(negedge clk); stop = 1'b0;
  endtask
  task automatic wait_idle();
    @(negedge clk);
    while (busy) @(negedge clk);
  endtask
  task automatic mchk(input string tag, input logic [7:0] a, input logic [7:0] e);
    @(negedge clk); rd_addr = a; #1;
    chk(tag, rd_data, e);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    // R1
    chk("R1 busy", busy, 1'b0);
    chk("R1 ptr", ptr, 8'h00);
    mchk("R1 mem", 8'h00, 8'h00);
    mchk("R1 mem", 8'hFF, 8'h00);

    // R2/R5/R6 single byte
    t_addr(8'h23); chk("R2 load", ptr, 8'h23);
    t_data(8'hA5); chk("R3 step", ptr, 8'h24);
    t_stop(); chk("R5 start", busy, 1'b1);
    mchk("R6 not yet", 8'h23, 8'h00);
    wait_idle();
    mchk("R6 written", 8'h23, 8'hA5);
    mchk("R6 neighbour", 8'h22, 8'h00);
    mchk("R6 neighbour", 8'h24, 8'h00);

    // R3 wrap inside page
    t_addr(8'h3E);
    t_data(8'h01); t_data(8'h02); t_data(8'h03); t_data(8'h04);
    chk("R3 wrap", ptr, 8'h32);
    t_stop(); wait_idle();
    mchk("R3 wrap", 8'h3F, 8'h02);
    mchk("R3 wrap", 8'h30, 8'h03);
    mchk("R3 no spill", 8'h40, 8'h00);

    // R4 overrun of 18 bytes
    t_addr(8'h50);
    for (int i = 1; i <= 18; i++) t_data(8'(i));
    t_stop(); wait_idle();
    mchk("R4 overwrite", 8'h50, 8'd17);
    mchk("R4 overwrite", 8'h51, 8'd18);
    mchk("R4 kept", 8'h52, 8'd3);
    mchk("R4 kept", 8'h5F, 8'd16);

    // R7 address only
    t_addr(8'h60); t_stop();
    chk("R7 no busy", busy, 1'b0);
    repeat (3) @(negedge clk);
    chk("R7 no busy", busy, 1'b0);

    // R2 re-address drops pending bytes
    t_addr(8'h60); t_data(8'h11); t_addr(8'h70); t_data(8'h22);
    t_stop(); wait_idle();
    mchk("R2 dropped", 8'h60, 8'h00);
    mchk("R2 kept", 8'h70, 8'h22);

    // R8 protection, R9 lower half unaffected
    wp = 1'b1;
    t_addr(8'h90); t_data(8'h5A); t_stop();
    chk("R8 no busy", busy, 1'b0);
    mchk("R8 unchanged", 8'h90, 8'h00);
    t_addr(8'h15); t_data(8'hC3); t_stop();
    chk("R9 busy", busy, 1'b1);
    wait_idle();
    mchk("R9 written", 8'h15, 8'hC3);
    wp = 1'b0;
    t_addr(8'hA0); t_data(8'h3C); t_stop(); wait_idle();
    mchk("R8 wp low", 8'hA0, 8'h3C);

    // R10 strobes during busy, R11 empty after commit
    t_addr(8'h05); t_data(8'h77); t_stop();
    t_addr(8'hC0); t_data(8'h99); t_stop();
    chk("R10 ptr hold", ptr, 8'h06);
    wait_idle();
    mchk("R10 ignored", 8'hC0, 8'h00);
    mchk("R10 commit", 8'h05, 8'h77);
    t_stop();
    chk("R11 empty", busy, 1'b0);

    // R11 priority: STOP over data in the same cycle
    t_addr(8'h08); t_data(8'h44);
    @(negedge clk); stop = 1'b1; data_valid = 1'b1; data = 8'hEE;
    @(negedge clk); stop = 1'b0; data_valid = 1'b0;
    chk("R11 prio ptr", ptr, 8'h09);
    wait_idle();
    mchk("R11 prio", 8'h08, 8'h44);
    mchk("R11 prio", 8'h09, 8'h00);

    // R6 full sweep against model
    for (int i = 0; i < 256; i++) mchk("R6 sweep", 8'(i), m_mem[i]);

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    #(200000 * 4);
    if (!done) begin
      done = 1'b1;
      checks++; fails++;
      $display("FAIL R5 watchdog act=running exp=finished");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end
endmodule